// File: doc/BRIEF.md
# Subroutine Return Unit with Shadow Restore

This block executes the return-from-subroutine operation of a small 8-bit microcontroller core. It keeps a hardware stack of return addresses, filled through a push port that the call logic drives. It also keeps a single set of shadow copies of the working register, the status register and the bank-select register, which an external strobe captures on a fast call or interrupt entry.

When a valid return word arrives, the unit pops the stack and loads the program counter from the entry that was on top. Bit 0 of the return word selects whether the three core registers are also reloaded from their shadows in the same operation. The cycle after an accepted return is a flush cycle. During that cycle the unit raises a stall indication and discards any instruction offered to it.

Popping an empty stack loads the program counter with zero and sets a sticky underflow flag.

Top module: `subr_return_unit`

## Requirements
- R1: While reset is asserted and directly after it, `pc_o`, `wreg_o`, `status_o` and `bsr_o` are zero, `stall_o` and `underflow_o` are low, and the stack holds no entries.
- R2: A return is recognised only when `instr_vld_i` is high and `instr_i[15:1]` equals the 15-bit value 0x0009, so the whole word is 0x0012 or 0x0013. Any other word, or a word offered with `instr_vld_i` low, changes no output.
- R3: An accepted return loads `pc_o` with the most recently pushed address that has not yet been popped, in last-in first-out order. The new value is visible after the clock edge that accepts the return. `pc_o` does not change at any other time.
- R4: An accepted return whose bit 0 (`instr_i[0]`) is 1 loads `wreg_o`, `status_o` and `bsr_o` from their shadow copies at the same edge that loads `pc_o`.
- R5: An accepted return whose bit 0 is 0 leaves `wreg_o`, `status_o` and `bsr_o` unchanged.
- R6: `stall_o` is high for exactly the one cycle after an accepted return. A return word offered while `stall_o` is high is discarded and changes no output.
- R7: A high `shadow_cap_i` copies `wreg_i`, `status_i` and `bsr_i` into the shadow copies without changing any output. It must never coincide with an accepted return.
- R8: An accepted return with an empty stack loads `pc_o` with zero and sets `underflow_o`. `underflow_o` then stays high until reset.
- R9: A push while the stack already holds DEPTH (31) entries is dropped. A push in the same cycle as an accepted return is also dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word |
| instr_vld_i | input | 1 | Instruction word valid |
| push_vld_i | input | 1 | Push a return address |
| push_addr_i | input | PC_W (21) | Return address to push |
| shadow_cap_i | input | 1 | Capture strobe for the shadow copies |
| wreg_i | input | DW (8) | Working register value to capture |
| status_i | input | DW (8) | Status register value to capture |
| bsr_i | input | DW (8) | Bank-select register value to capture |
| pc_o | output | PC_W (21) | Program counter |
| wreg_o | output | DW (8) | Restored working register |
| status_o | output | DW (8) | Restored status register |
| bsr_o | output | DW (8) | Restored bank-select register |
| stall_o | output | 1 | Flush cycle after a return |
| underflow_o | output | 1 | Sticky stack underflow flag |

## Verification
Every result of an accepted return is due one clock edge after the edge that samples the return word: the program counter, the restored registers, the underflow flag and the raised stall. The stall falls again one edge after that.

Pushes and shadow captures are internal state only. They show up at the ports only through a later return.

The bench drives each stimulus at a falling edge and advances its reference model by exactly one edge. It then compares every output at the next falling edge, so each result is checked in the cycle it is due and never at an edge.

// File: rtl/srt_pkg.sv
package srt_pkg;
   // upper fifteen bits of the return word; bit 0 is the restore option
   localparam logic [14:0] RET_OPC_HI = 15'h0009;

   function automatic logic is_return(input logic [15:0] word);
      return word[15:1] == RET_OPC_HI;
   endfunction
endpackage

// File: rtl/ret_decode.sv
module ret_decode (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] instr_i,
   input  logic        instr_vld_i,
   output logic        ret_go_o,
   output logic        restore_go_o,
   output logic        stall_o
);
   logic flush_q;

   // a word arriving in the flush cycle is discarded
   assign ret_go_o     = instr_vld_i && srt_pkg::is_return(instr_i) && !flush_q;
   assign restore_go_o = ret_go_o && instr_i[0];
   assign stall_o      = flush_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flush_q <= 1'b0;
      else        flush_q <= ret_go_o;
   end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
   parameter int PC_W  = 21,
   parameter int DEPTH = 31
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push_i,
   input  logic [PC_W-1:0] push_addr_i,
   input  logic            pop_i,
   output logic [PC_W-1:0] tos_o,
   output logic            empty_o
);
   localparam int PTR_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

   if (DEPTH < 2)  $error("ret_stack: DEPTH must be at least 2");
   if (PC_W < 1)   $error("ret_stack: PC_W must be positive");

   logic [PTR_W-1:0] cnt_q;
   logic [PTR_W-1:0] rd_idx;
   logic             wr_en;
   logic [PC_W-1:0]  slot [DEPTH];

   assign empty_o = (cnt_q == '0);
   assign wr_en   = push_i && !pop_i && (cnt_q != FULL_CNT);
   assign rd_idx  = empty_o ? '0 : cnt_q - 1'b1;
   assign tos_o   = slot[rd_idx];

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic [PC_W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 ent_q <= '0;
         else if (wr_en && cnt_q == PTR_W'(e))      ent_q <= push_addr_i;
      end
      assign slot[e] = ent_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (pop_i && !empty_o) cnt_q <= cnt_q - 1'b1;
      else if (wr_en)             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
   parameter int DW   = 8,
   parameter int NREG = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap_i,
   input  logic [NREG-1:0][DW-1:0] cap_val_i,
   input  logic                    restore_i,
   output logic [NREG-1:0][DW-1:0] live_o
);
   if (DW < 1)   $error("shadow_bank: DW must be positive");
   if (NREG < 1) $error("shadow_bank: NREG must be positive");

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [DW-1:0] shd_q;
      logic [DW-1:0] live_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shd_q  <= '0;
            live_q <= '0;
         end else begin
            if (cap_i)     shd_q  <= cap_val_i[r];
            if (restore_i) live_q <= shd_q;
         end
      end
      assign live_o[r] = live_q;
   end
endmodule

// File: rtl/subr_return_unit.sv
module subr_return_unit #(
   parameter int PC_W  = 21,
   parameter int DEPTH = 31,
   parameter int DW    = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [15:0]     instr_i,
   input  logic            instr_vld_i,
   input  logic            push_vld_i,
   input  logic [PC_W-1:0] push_addr_i,
   input  logic            shadow_cap_i,
   input  logic [DW-1:0]   wreg_i,
   input  logic [DW-1:0]   status_i,
   input  logic [DW-1:0]   bsr_i,
   output logic [PC_W-1:0] pc_o,
   output logic [DW-1:0]   wreg_o,
   output logic [DW-1:0]   status_o,
   output logic [DW-1:0]   bsr_o,
   output logic            stall_o,
   output logic            underflow_o
);
   localparam int NREG = 3;

   logic                    ret_go, restore_go, stk_empty;
   logic [PC_W-1:0]         tos;
   logic [NREG-1:0][DW-1:0] live;
   logic [PC_W-1:0]         pc_q;
   logic                    uf_q;

   ret_decode u_dec (
      .clk, .rst_n, .instr_i, .instr_vld_i,
      .ret_go_o(ret_go), .restore_go_o(restore_go), .stall_o(stall_o)
   );

   ret_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stk (
      .clk, .rst_n,
      .push_i(push_vld_i), .push_addr_i(push_addr_i),
      .pop_i(ret_go), .tos_o(tos), .empty_o(stk_empty)
   );

   shadow_bank #(.DW(DW), .NREG(NREG)) u_shd (
      .clk, .rst_n,
      .cap_i(shadow_cap_i), .cap_val_i({bsr_i, status_i, wreg_i}),
      .restore_i(restore_go), .live_o(live)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
         uf_q <= 1'b0;
      end else if (ret_go) begin
         pc_q <= stk_empty ? '0 : tos;
         if (stk_empty) uf_q <= 1'b1;
      end
   end

   assign pc_o        = pc_q;
   assign underflow_o = uf_q;
   assign wreg_o      = live[0];
   assign status_o    = live[1];
   assign bsr_o       = live[2];
endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
   parameter int PC_W = 21,
   parameter int DW   = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [15:0]     instr_i,
   input logic            instr_vld_i,
   input logic            shadow_cap_i,
   input logic [PC_W-1:0] pc_o,
   input logic [DW-1:0]   wreg_o,
   input logic [DW-1:0]   status_o,
   input logic [DW-1:0]   bsr_o,
   input logic            stall_o,
   input logic            underflow_o
);
   logic acc;
   assign acc = instr_vld_i && (instr_i[15:1] == 15'h0009) && !stall_o;

   AST_CAP_NOT_WITH_RET: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && shadow_cap_i)); // R7
   AST_STALL_AFTER_RET: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> stall_o); // R6
   AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |=> !stall_o); // R6
   AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> $stable(pc_o)); // R3
   AST_REGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && instr_i[0]) |=> $stable({wreg_o, status_o, bsr_o})); // R5
   AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_o |=> underflow_o); // R8
   AST_UF_PC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underflow_o) |-> (pc_o == '0)); // R8
endmodule

bind subr_return_unit srt_checker #(.PC_W(PC_W), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .instr_vld_i(instr_vld_i),
   .shadow_cap_i(shadow_cap_i), .pc_o(pc_o), .wreg_o(wreg_o),
   .status_o(status_o), .bsr_o(bsr_o), .stall_o(stall_o),
   .underflow_o(underflow_o)
);

// File: tb/subr_return_unit_tb_top.sv
module subr_return_unit_tb_top;
   localparam int PC_W = 21, DEPTH = 31, DW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [15:0] instr_i = '0;
   logic instr_vld_i = 0, push_vld_i = 0, shadow_cap_i = 0;
   logic [PC_W-1:0] push_addr_i = '0;
   logic [DW-1:0] wreg_i = '0, status_i = '0, bsr_i = '0;
   logic [PC_W-1:0] pc_o;
   logic [DW-1:0] wreg_o, status_o, bsr_o;
   logic stall_o, underflow_o;

   subr_return_unit #(.PC_W(PC_W), .DEPTH(DEPTH), .DW(DW)) dut_i (.*);

   int n_chk = 0, n_bad = 0;
   logic [PC_W-1:0] m_stk [DEPTH];
   int m_cnt = 0;
   logic [PC_W-1:0] m_pc = '0;
   logic [DW-1:0] m_w = '0, m_s = '0, m_b = '0, m_sw = '0, m_ss = '0, m_sb = '0;
   logic m_stall = 0, m_uf = 0;

   function automatic logic is_ret(input logic [15:0] w);
      return w[15:1] == 15'h0009;
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag,  "pc",     64'(pc_o),     64'(m_pc));
      chk(tag,  "wreg",   64'(wreg_o),   64'(m_w));
      chk(tag,  "status", 64'(status_o), 64'(m_s));
      chk(tag,  "bsr",    64'(bsr_o),    64'(m_b));
      chk("R6", "stall",  64'(stall_o),  64'(m_stall));
      chk("R8", "uflow",  64'(underflow_o), 64'(m_uf));
   endtask

   // called at a falling edge; applies one cycle and checks at the next falling edge
   task automatic cyc(input logic [15:0] ins, input logic iv, input logic pv,
                      input logic [PC_W-1:0] pa, input logic cap,
                      input logic [DW-1:0] w, input logic [DW-1:0] s,
                      input logic [DW-1:0] b, input string tag);
      logic acc;
      instr_i = ins; instr_vld_i = iv; push_vld_i = pv; push_addr_i = pa;
      shadow_cap_i = cap; wreg_i = w; status_i = s; bsr_i = b;
      acc = iv && is_ret(ins) && !m_stall;
      if (acc) begin
         if (m_cnt == 0) begin m_pc = '0; m_uf = 1'b1; end
         else begin m_cnt--; m_pc = m_stk[m_cnt]; end
         if (ins[0]) begin m_w = m_sw; m_s = m_ss; m_b = m_sb; end
      end else if (pv && m_cnt < DEPTH) begin
         m_stk[m_cnt] = pa; m_cnt++;
      end
      if (cap) begin m_sw = w; m_ss = s; m_sb = b; end
      m_stall = acc;
      @(negedge clk);
      instr_vld_i = 0; push_vld_i = 0; shadow_cap_i = 0;
      check_all(tag);
   endtask

   task automatic nop(input string tag);
      cyc(16'h0000, 0, 0, '0, 0, '0, '0, '0, tag);
   endtask
   task automatic push(input logic [PC_W-1:0] a, input string tag);
      cyc(16'h0000, 0, 1, a, 0, '0, '0, '0, tag);
   endtask
   task automatic ret(input logic s, input string tag);
      cyc({15'h0009, s}, 1, 0, '0, 0, '0, '0, '0, tag);
   endtask
   task automatic capture(input logic [DW-1:0] w, input logic [DW-1:0] s, input logic [DW-1:0] b);
      cyc(16'h0000, 0, 0, '0, 1, w, s, b, "R7");
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check_all("R1");                       // R1 during reset
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");                       // R1 after reset

      // R8: pop an empty stack
      ret(1'b0, "R8");
      nop("R8");

      // R7 / R4: capture, then restoring return
      capture(8'hA5, 8'h1C, 8'h07);
      push(21'h1ABCDE, "R3");
      ret(1'b1, "R4");
      nop("R4");

      // R5: non-restoring return keeps registers
      capture(8'h11, 8'h22, 8'h33);
      push(21'h000123, "R3");
      ret(1'b0, "R5");
      nop("R5");

      // R2: near-miss words and invalid strobe
      push(21'h0F0F0F, "R2");
      cyc(16'h0014, 1, 0, '0, 0, '0, '0, '0, "R2");
      cyc(16'h0092, 1, 0, '0, 0, '0, '0, '0, "R2");
      cyc(16'h1013, 1, 0, '0, 0, '0, '0, '0, "R2");
      cyc(16'h0013, 0, 0, '0, 0, '0, '0, '0, "R2");

      // R6: return offered during the flush cycle is dropped
      push(21'h055555, "R6");
      ret(1'b0, "R6");
      ret(1'b1, "R6");
      ret(1'b0, "R6");

      // R9: push together with a return is dropped
      cyc({15'h0009, 1'b0}, 1, 1, 21'h1FFFFF, 0, '0, '0, '0, "R9");
      nop("R9");

      // R9 / R3: fill past full, then unwind in LIFO order
      for (int i = 0; i < DEPTH + 3; i++) push(PC_W'(21'h100000 + i * 37), "R9");
      for (int i = 0; i < DEPTH + 1; i++) begin ret(1'b0, "R3"); nop("R3"); end

      // random mix
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic [15:0] w;
         r = int'($urandom % 10);
         case (r)
            0, 1, 2, 3: push(PC_W'($urandom), "R9");
            4, 5: ret(1'($urandom), "R3");
            6: capture(8'($urandom), 8'($urandom), 8'($urandom));
            7: begin
               w = 16'($urandom);
               if (is_ret(w)) w[15] = 1'b1;
               cyc(w, 1, 0, '0, 0, '0, '0, '0, "R2");
            end
            8: cyc({15'h0009, 1'($urandom)}, 1, 1, PC_W'($urandom), 0, '0, '0, '0, "R9");
            default: nop("R5");
         endcase
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule